// File: doc/BRIEF.md
# Virtual Channel to Transfer Engine Allocator

This block shares a small pool of physical transfer engines (6 by default) among a larger set of virtual request channels (16 by default). Software-side agents post one command per cycle on a small command bus: issue work on a channel, terminate a channel, pause it, or resume it. A channel that gets work while it holds no engine waits in a first-come pending queue. Every free engine, lowest index first, takes the oldest waiting channel. A grant raises a one-cycle start pulse for that engine.

Each engine reports through its own idle line when its bound channel has no further work to do. That report releases the engine: the engine-side and the channel-side entries of the binding are both cleared, and the engine goes back into the free pool. Terminating a bound channel stops its engine with a one-cycle stop pulse and frees the engine at once. Terminating or pausing a channel that is still waiting takes it out of the queue. Descriptor storage, the data path and interrupts are handled by other blocks.

Top module: `vchan_alloc`

## Requirements
- R1: After reset no engine is valid, no channel is bound, the queue is empty and neither start nor stop pulses are raised.
- R2: An issue command (`cmd_op`=0) on an unbound, unpaused channel appends it to the tail of the pending queue only when it is not already queued. A second issue of a queued channel adds no second entry.
- R3: Each cycle, when the queue is non-empty, the lowest-indexed engine with `eng_valid` low is bound to the queue head. Channels are served oldest first. The binding and a one-cycle `eng_start` pulse for that engine appear together one cycle after the grant decision, and at most one engine starts per cycle.
- R4: When every engine is busy, waiting channels stay unbound until an engine is freed. The freed engine is granted on the cycle after it is seen free.
- R5: An `eng_idle` report on a valid engine clears `eng_valid`, the engine's channel entry and that channel's `ch_bound` bit at the next edge. An idle report on an engine that is not valid has no effect.
- R6: A terminate command (`cmd_op`=1) on a bound channel raises `eng_stop` for its engine for one cycle and clears the binding at the same edge. The engine is then free for the next pending channel.
- R7: A terminate command on a queued channel removes it from the queue without any stop pulse, so it is never granted.
- R8: A pause command (`cmd_op`=2) on a queued channel removes it from the queue. An issue on a paused unbound channel records work but does not queue it. A resume command (`cmd_op`=3) re-queues an unbound paused channel only if it has recorded work.
- R9: A command whose channel index is 16 or more is ignored, with no aliasing onto a lower channel.
- R10: An issue on a channel that already holds an engine creates no queue entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 issue, 1 terminate, 2 pause, 3 resume |
| cmd_ch | input | 5 | Target channel index; values of 16 or more are ignored |
| eng_idle | input | 6 | Per engine: bound channel has no further work |
| eng_valid | output | 6 | Per engine: currently bound |
| eng_ch | output | 24 | Channel bound to each engine, 4 bits per engine |
| eng_start | output | 6 | One-cycle pulse on a newly bound engine |
| eng_stop | output | 6 | One-cycle pulse on an engine stopped by terminate |
| ch_bound | output | 16 | Per channel: holds an engine |
| ch_eng | output | 48 | Engine held by each channel, 3 bits per channel |

## Verification
On every cycle, the assertions check four properties. The two halves of the binding table must agree. A channel is never queued and bound at once, and the queued flags match the queue depth. At most one engine starts per cycle, only on a bound engine. Release, stop and grant must leave the engine in the state each one implies. The order in which channels are served, the ascending choice of engine, and the removal of paused or terminated channels can only be shown by the bench's scenarios. The same holds for the conditional re-queue on resume and the rejection of out-of-range indices. The bench sweeps a full permutation of all channels through the pool.

// File: rtl/vca_pkg.sv
package vca_pkg;
  typedef enum logic [1:0] {
    OP_ISSUE  = 2'd0,
    OP_TERM   = 2'd1,
    OP_PAUSE  = 2'd2,
    OP_RESUME = 2'd3
  } vca_op_e;

  localparam int DEF_ENGINES  = 6;
  localparam int DEF_CHANNELS = 16;
endpackage

// File: rtl/vca_queue.sv
module vca_queue #(
  parameter int NUM_CH = 16,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              rm,
  input  logic [CW-1:0]     rm_ch,
  input  logic              push,
  input  logic [CW-1:0]     push_ch,
  output logic [CW-1:0]     head,
  output logic [CW:0]       depth,
  output logic [NUM_CH-1:0] queued
);
  logic [CW-1:0]     slot_q [NUM_CH];
  logic [CW-1:0]     slot_d [NUM_CH];
  logic [CW:0]       cnt_q, cnt_d;
  logic [NUM_CH-1:0] qd_q, qd_d;
  logic              rm_hit;

  // True when slot i is live and holds the channel being removed
  function automatic logic slot_match(input int i, input logic [CW:0] n,
                                      input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (i < int'(n)) && (a == b);
  endfunction

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    qd_d   = qd_q;
    rm_hit = 1'b0;
    if (pop) begin
      for (int i = 0; i < NUM_CH - 1; i++) slot_d[i] = slot_q[i+1];
      qd_d[slot_q[0]] = 1'b0;
      cnt_d = cnt_q - 1'b1;
    end else if (rm) begin
      for (int i = 0; i < NUM_CH; i++) begin
        rm_hit = rm_hit | slot_match(i, cnt_q, slot_q[i], rm_ch);
        if (rm_hit) slot_d[i] = (i < NUM_CH - 1) ? slot_q[(i + 1) % NUM_CH] : '0;
      end
      if (rm_hit) begin
        qd_d[rm_ch] = 1'b0;
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (push) begin
      slot_d[cnt_d[CW-1:0]] = push_ch;
      qd_d[push_ch] = 1'b1;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) slot_q[i] <= '0;
      cnt_q <= '0;
      qd_q  <= '0;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      qd_q   <= qd_d;
    end
  end

  assign head   = slot_q[0];
  assign depth  = cnt_q;
  assign queued = qd_q;

  // R2
  flags_match_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(qd_q) == int'(cnt_q));
  // R2
  no_double_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !qd_q[push_ch]);
  // R3
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/vca_pick.sv
module vca_pick #(
  parameter int N = 6,
  localparam int EW = $clog2(N)
) (
  input  logic [N-1:0]  free,
  output logic          any,
  output logic [EW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free[i]) idx = EW'(i);
    end
  end
  assign any = |free;
endmodule

// File: rtl/vca_bind.sv
module vca_bind #(
  parameter int NUM_ENG = 6,
  parameter int NUM_CH  = 16,
  localparam int EW = $clog2(NUM_ENG),
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ENG-1:0]    clr,
  input  logic                  set,
  input  logic [EW-1:0]         set_eng,
  input  logic [CW-1:0]         set_ch,
  output logic [NUM_ENG-1:0]    eng_valid,
  output logic [NUM_ENG*CW-1:0] eng_ch,
  output logic [NUM_CH-1:0]     ch_bound,
  output logic [NUM_CH*EW-1:0]  ch_eng
);
  logic [NUM_ENG-1:0] ev_q;
  logic [CW-1:0]      ech_q [NUM_ENG];
  logic [NUM_CH-1:0]  cb_q;
  logic [EW-1:0]      ceng_q [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      cb_q <= '0;
      for (int e = 0; e < NUM_ENG; e++) ech_q[e] <= '0;
      for (int c = 0; c < NUM_CH; c++) ceng_q[c] <= '0;
    end else begin
      for (int e = 0; e < NUM_ENG; e++) begin
        if (clr[e]) begin
          ev_q[e] <= 1'b0;
          ech_q[e] <= '0;
          cb_q[ech_q[e]] <= 1'b0;
          ceng_q[ech_q[e]] <= '0;
        end
      end
      if (set) begin
        ev_q[set_eng]   <= 1'b1;
        ech_q[set_eng]  <= set_ch;
        cb_q[set_ch]    <= 1'b1;
        ceng_q[set_ch]  <= set_eng;
      end
    end
  end

  assign eng_valid = ev_q;
  assign ch_bound  = cb_q;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    assign eng_ch[e*CW +: CW] = ech_q[e];
    // R5
    two_sided_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q[e] |-> (cb_q[ech_q[e]] && ceng_q[ech_q[e]] == EW'(e)));
    // R5
    clear_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[e] |-> ev_q[e]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_eng[c*EW +: EW] = ceng_q[c];
  end

  // R3
  set_free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> !ev_q[set_eng]);
  // R5
  bound_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cb_q) == $countones(ev_q));
endmodule

// File: rtl/vchan_alloc.sv
module vchan_alloc
  import vca_pkg::*;
#(
  parameter int NUM_ENG = DEF_ENGINES,
  parameter int NUM_CH  = DEF_CHANNELS,
  localparam int EW  = $clog2(NUM_ENG),
  localparam int CW  = $clog2(NUM_CH),
  localparam int CIW = CW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [CIW-1:0]        cmd_ch,
  input  logic [NUM_ENG-1:0]    eng_idle,
  output logic [NUM_ENG-1:0]    eng_valid,
  output logic [NUM_ENG*CW-1:0] eng_ch,
  output logic [NUM_ENG-1:0]    eng_start,
  output logic [NUM_ENG-1:0]    eng_stop,
  output logic [NUM_CH-1:0]     ch_bound,
  output logic [NUM_CH*EW-1:0]  ch_eng
);
  vca_op_e            op;
  logic               hit;
  logic [CW-1:0]      c;
  logic               c_bound, c_free_after;
  logic [EW-1:0]      c_eng;
  logic [NUM_ENG-1:0] rel_vec, stop_vec, clr_vec;
  logic [NUM_CH-1:0]  work_q, pause_q, work_clr;
  logic [NUM_CH-1:0]  queued;
  logic [CW-1:0]      q_head;
  logic [CW:0]        q_depth;
  logic               push, rm, grant, any_free;
  logic [EW-1:0]      free_idx;
  logic [NUM_ENG-1:0] start_q, stop_q;

  // Channel index is usable only when it names an existing channel
  function automatic logic in_range(input logic [CIW-1:0] idx);
    return int'(idx) < NUM_CH;
  endfunction

  function automatic logic [NUM_ENG-1:0] eng_onehot(input logic [EW-1:0] e);
    return NUM_ENG'(1) << e;
  endfunction

  assign op      = vca_op_e'(cmd_op);
  assign hit     = cmd_valid && in_range(cmd_ch);
  assign c       = cmd_ch[CW-1:0];
  assign c_bound = ch_bound[c];
  assign c_eng   = ch_eng[int'(c)*EW +: EW];

  assign rel_vec      = eng_valid & eng_idle;
  assign stop_vec     = (hit && op == OP_TERM && c_bound) ? eng_onehot(c_eng) : '0;
  assign clr_vec      = rel_vec | stop_vec;
  assign c_free_after = !c_bound || rel_vec[c_eng];

  assign push = hit && !queued[c] && c_free_after &&
                ((op == OP_ISSUE && !pause_q[c]) ||
                 (op == OP_RESUME && pause_q[c] && work_q[c]));
  assign rm   = hit && (op == OP_TERM || op == OP_PAUSE) && queued[c];

  always_comb begin
    work_clr = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      if (rel_vec[e]) work_clr[eng_ch[e*CW +: CW]] = 1'b1;
    end
  end

  vca_pick #(.N(NUM_ENG)) u_pick (
    .free (~eng_valid),
    .any  (any_free),
    .idx  (free_idx)
  );

  assign grant = any_free && (q_depth != '0) && !rm;

  vca_queue #(.NUM_CH(NUM_CH)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop     (grant),
    .rm      (rm),
    .rm_ch   (c),
    .push    (push),
    .push_ch (c),
    .head    (q_head),
    .depth   (q_depth),
    .queued  (queued)
  );

  vca_bind #(.NUM_ENG(NUM_ENG), .NUM_CH(NUM_CH)) u_bind (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_vec),
    .set       (grant),
    .set_eng   (free_idx),
    .set_ch    (q_head),
    .eng_valid (eng_valid),
    .eng_ch    (eng_ch),
    .ch_bound  (ch_bound),
    .ch_eng    (ch_eng)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      pause_q <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      start_q <= grant ? eng_onehot(free_idx) : '0;
      stop_q  <= stop_vec;
      for (int i = 0; i < NUM_CH; i++) begin
        if (hit && c == CW'(i) && op == OP_ISSUE)      work_q[i] <= 1'b1;
        else if (hit && c == CW'(i) && op == OP_TERM)  work_q[i] <= 1'b0;
        else if (work_clr[i])                          work_q[i] <= 1'b0;
        if (hit && c == CW'(i) && op == OP_PAUSE)       pause_q[i] <= 1'b1;
        else if (hit && c == CW'(i) && op == OP_RESUME) pause_q[i] <= 1'b0;
      end
    end
  end

  assign eng_start = start_q;
  assign eng_stop  = stop_q;

  // R3
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));
  // R2
  queue_bind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (queued & ch_bound) == '0);

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_prop
    // R3
    start_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[e] |-> eng_valid[e]);
    // R6
    stop_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop[e] |-> !eng_valid[e]);
    // R5
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid[e] && eng_idle[e]) |=> !eng_valid[e]);
  end
endmodule

// File: tb/vchan_alloc_tb.sv
`timescale 1ns/1ps
module vchan_alloc_tb;
  localparam int NE = 6;
  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [4:0]  cmd_ch = 5'd0;
  logic [5:0]  eng_idle = 6'd0;
  logic [5:0]  eng_valid, eng_start, eng_stop;
  logic [23:0] eng_ch;
  logic [15:0] ch_bound;
  logic [47:0] ch_eng;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vchan_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .eng_idle(eng_idle), .eng_valid(eng_valid),
    .eng_ch(eng_ch), .eng_start(eng_start), .eng_stop(eng_stop),
    .ch_bound(ch_bound), .ch_eng(ch_eng)
  );

  function automatic int perm(input int i);
    return (i * 7 + 3) % NC;
  endfunction
  function automatic int ech(input int e);
    return int'(eng_ch[e*4 +: 4]);
  endfunction
  function automatic int cheng(input int ch);
    return int'(ch_eng[ch*3 +: 3]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [4:0] ch);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle_pulse(input logic [5:0] m);
    eng_idle = m;
    @(negedge clk);
    eng_idle = 6'd0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(eng_valid == 0, "R1 eng_valid", int'(eng_valid), 0);
    check(ch_bound == 0, "R1 ch_bound", int'(ch_bound), 0);
    check(eng_start == 0 && eng_stop == 0, "R1 pulses", int'({eng_start, eng_stop}), 0);

    // R2 R3: full permutation sweep through the pool
    for (int i = 0; i < NC; i++) do_cmd(2'd0, 5'(perm(i)));
    wait_cyc(3);
    for (int e = 0; e < NE; e++) begin
      check(eng_valid[e], "R3 engine bound", int'(eng_valid[e]), 1);
      check(ech(e) == perm(e), "R3 oldest first", ech(e), perm(e));
      check(cheng(perm(e)) == e, "R3 channel side", cheng(perm(e)), e);
    end
    check($countones(ch_bound) == NE, "R4 others wait", $countones(ch_bound), NE);
    do_cmd(2'd0, 5'(perm(0)));  // R10 issue on bound channel
    do_cmd(2'd0, 5'(perm(7)));  // R2 duplicate issue on queued channel
    for (int j = 0; j < 10; j++) begin
      int r, old;
      r = (j * 5) % NE;
      old = ech(r);
      idle_pulse(6'(1) << r);
      check(!eng_valid[r], "R5 release clears engine", int'(eng_valid[r]), 0);
      check(!ch_bound[old], "R5 release clears channel", int'(ch_bound[old]), 0);
      @(negedge clk);
      check(eng_valid[r] && ech(r) == perm(NE + j), "R4 freed engine regranted", ech(r), perm(NE + j));
      check(eng_start == (6'(1) << r), "R3 start pulse", int'(eng_start), 1 << r);
    end
    idle_pulse(6'h3f);
    wait_cyc(4);
    check(eng_valid == 0, "R2 R10 no duplicate entries", int'(eng_valid), 0);
    check(ch_bound == 0, "R5 all channels unbound", int'(ch_bound), 0);
    idle_pulse(6'h3f);
    wait_cyc(2);
    check(eng_valid == 0 && eng_stop == 0, "R5 idle on free engine ignored", int'(eng_valid), 0);

    // R3: ascending engine choice among scattered free engines
    do_reset();
    for (int i = 0; i < NE; i++) do_cmd(2'd0, 5'(i));
    wait_cyc(3);
    idle_pulse(6'b010010);
    check(!eng_valid[1] && !eng_valid[4], "R5 two released", int'(eng_valid), 6'b101101);
    do_cmd(2'd0, 5'd10);
    do_cmd(2'd0, 5'd11);
    wait_cyc(2);
    check(ech(1) == 10, "R3 lower engine first", ech(1), 10);
    check(ech(4) == 11, "R3 next engine", ech(4), 11);

    // R4 R6: terminate of a bound channel frees its engine for a waiter
    do_cmd(2'd0, 5'd12);
    wait_cyc(2);
    check(!ch_bound[12], "R4 waits while all busy", int'(ch_bound[12]), 0);
    do_cmd(2'd1, 5'd11);
    check(eng_stop == 6'b010000, "R6 stop pulse", int'(eng_stop), 6'b010000);
    check(!eng_valid[4] && !ch_bound[11], "R6 binding cleared", int'(eng_valid[4]), 0);
    @(negedge clk);
    check(eng_valid[4] && ech(4) == 12, "R6 freed engine regranted", ech(4), 12);

    // R7: terminate of a queued channel
    do_cmd(2'd0, 5'd13);
    do_cmd(2'd0, 5'd14);
    do_cmd(2'd1, 5'd13);
    check(eng_stop == 0, "R7 no stop for queued", int'(eng_stop), 0);
    idle_pulse(6'b000001);
    @(negedge clk);
    check(ech(0) == 14, "R7 removed channel skipped", ech(0), 14);
    wait_cyc(2);
    check(!ch_bound[13], "R7 never granted", int'(ch_bound[13]), 0);

    // R8: pause, issue while paused, resume with and without work
    do_cmd(2'd2, 5'd7);
    do_cmd(2'd0, 5'd7);
    do_cmd(2'd0, 5'd8);
    idle_pulse(6'b000010);
    @(negedge clk);
    check(ech(1) == 8, "R8 paused issue not queued", ech(1), 8);
    do_cmd(2'd3, 5'd7);
    idle_pulse(6'b000100);
    @(negedge clk);
    check(ech(2) == 7 && eng_valid[2], "R8 resume requeues", ech(2), 7);
    do_cmd(2'd2, 5'd9);
    do_cmd(2'd3, 5'd9);
    idle_pulse(6'b001000);
    wait_cyc(3);
    check(!eng_valid[3], "R8 resume without work", int'(eng_valid[3]), 0);
    do_cmd(2'd0, 5'd9);
    wait_cyc(2);
    check(ech(3) == 9, "R8 refill engine 3", ech(3), 9);
    do_cmd(2'd0, 5'd1);
    do_cmd(2'd2, 5'd1);
    do_cmd(2'd0, 5'd6);
    idle_pulse(6'b000001);
    @(negedge clk);
    check(ech(0) == 6, "R8 pause removes queued", ech(0), 6);

    // R9: out-of-range indices
    idle_pulse(6'b000010);
    wait_cyc(2);
    do_cmd(2'd0, 5'd16);
    do_cmd(2'd0, 5'd29);
    wait_cyc(3);
    check(!eng_valid[1], "R9 issue out of range", int'(eng_valid[1]), 0);
    do_cmd(2'd1, 5'd21);
    check(eng_stop == 0 && eng_valid[5], "R9 terminate out of range", int'(eng_stop), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule